// File: doc/BRIEF.md
# Configuration Space Access Port Decoder

This block sits on a simple I/O request bus and turns the two-port configuration access scheme into requests for a per-function configuration register file. A 4-byte write to the address port at I/O 0xCF8 loads a selector word. That word names a slot, a function and a register offset. An access to any of the four data ports 0xCFC to 0xCFF then reads or writes 1, 2 or 4 bytes of the selected function's registers. The byte offset used is the stored register offset plus the low two bits of the data port address.

Every access is checked before it goes out. The block drops a data access when its size is not 1, 2 or 4, when its offset is not a multiple of its size, or when the selected slot and function are marked absent in a presence vector. A dropped read returns all ones and a dropped write has no effect. When a read covers the header-type byte at offset 0x0E, the block rewrites bit 7 of that byte in the returned data. The bit comes from the live slot occupancy: it is 1 when more than one function in the slot is present.

A valid data access goes to the register file in the same cycle as the I/O request. The register file answers combinationally. The I/O response, registered, follows one cycle later.

Top module: `cfg_port_decoder`

## Requirements
- R1: A write of size 4 to port 0xCF8 stores the 32-bit selector. The selector fields are: offset in bits 7:0, function in bits 10:8, slot in bits 15:11, bus in bits 23:16 and enable in bit 31. The bus and enable fields are stored but do not change which function is decoded. After reset the selector is zero.
- R2: A write to port 0xCF8 of any size other than 4 leaves the selector unchanged. A read of port 0xCF8 returns 0xFFFFFFFF.
- R3: For a data access, the effective offset is (selector offset + io_addr - 0xCFC) modulo 256.
- R4: When a data access is accepted, cfg_req is high in the same cycle. In that cycle cfg_slot, cfg_func, cfg_off, cfg_we, cfg_size and cfg_wdata carry the selector slot and function, the effective offset, and the request's direction, size and write data.
- R5: An access is dropped when io_size is not 1, 2 or 4, or when the effective offset is not a multiple of io_size. A dropped access raises no cfg_req. A dropped read returns 0xFFFFFFFF.
- R6: Function f of slot s is present when bit s*8+f of `present` is 1. An access to an absent function raises no cfg_req. Such a read returns 0xFFFFFFFF.
- R7: io_rsp_valid is high exactly one cycle after every claimed request. For an accepted read, io_rdata holds cfg_rdata with all bytes above io_size cleared to zero.
- R8: If an accepted read covers offset 0x0E, bit 7 of that byte in io_rdata is set when two or more bits of the slot's 8-bit presence field are 1, and cleared otherwise. The byte sits in lane (0x0E - effective offset).
- R9: Requests to any port other than 0xCF8 and 0xCFC..0xCFF raise neither cfg_req nor io_rsp_valid.
- R10: During and right after reset, io_rsp_valid and cfg_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | I/O request strobe, one cycle per access |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| io_wdata | input | 32 | Right-justified write data |
| io_rsp_valid | output | 1 | Response for a claimed request, one cycle later |
| io_rdata | output | 32 | Read data of the response |
| present | input | 256 | Function presence, bit slot*8+function |
| cfg_req | output | 1 | Accepted access to the register file |
| cfg_we | output | 1 | Direction of the forwarded access |
| cfg_slot | output | 5 | Selected slot |
| cfg_func | output | 3 | Selected function |
| cfg_off | output | 8 | Effective byte offset |
| cfg_size | output | 3 | Forwarded access size in bytes |
| cfg_wdata | output | 32 | Forwarded write data |
| cfg_rdata | input | 32 | Register file read data, right-justified, same cycle |

## Verification
The hardest case to reach is a header-type rewrite that actually changes a bit. The register file's raw bit 7 must differ from the occupancy result, and it must do so in each of the byte lanes the byte can occupy. The bench's register file model returns each byte as its offset XORed with the slot and function number. The bench then picks a multi-function slot whose raw header byte has bit 7 clear, and a single-function slot whose raw byte has bit 7 set. It reads offset 0x0E through 1-, 2- and 4-byte accesses, reaching it through different data ports.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [15:0] ADDR_PORT  = 16'h0CF8;
  localparam logic [15:0] DATA_BASE  = 16'h0CFC;
  localparam logic [7:0]  HDR_OFF    = 8'h0E;
  localparam int          FUNCS      = 8;

  typedef struct packed {
    logic       en;
    logic [6:0] rsvd;
    logic [7:0] bus;
    logic [4:0] slot;
    logic [2:0] func;
    logic [7:0] off;
  } cfg_sel_t;

  function automatic logic [7:0] eff_offset(input logic [7:0] base, input logic [1:0] lane);
    return base + {6'd0, lane};
  endfunction

  function automatic logic legal_size(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic is_aligned(input logic [7:0] off, input logic [2:0] sz);
    return (off & {5'd0, sz - 3'd1}) == 8'd0;
  endfunction

  function automatic logic [31:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] hdr_fix(input logic [31:0] d, input logic [7:0] off,
                                          input logic [2:0] sz, input logic mf);
    logic [8:0]  lo, hi;
    logic [7:0]  lane;
    logic [31:0] r;
    r    = d;
    lo   = {1'b0, off};
    hi   = {1'b0, off} + {6'd0, sz};
    lane = HDR_OFF - off;
    if ((lo <= {1'b0, HDR_OFF}) && ({1'b0, HDR_OFF} < hi))
      r[{lane[1:0], 3'd7}] = mf;
    return r;
  endfunction
endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
  import cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] wdata,
  output cfg_sel_t    sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sel_q <= '0;
    else if (load) sel_q <= cfg_sel_t'(wdata);
  end
endmodule

// File: rtl/cfg_access_check.sv
module cfg_access_check
  import cfg_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  cfg_sel_t                     sel,
  input  logic [1:0]                   lane,
  input  logic [2:0]                   size,
  input  logic [NUM_SLOTS*FUNCS-1:0]   present,
  output logic [7:0]                   off,
  output logic                         acc_ok,
  output logic                         multi_fn
);
  logic [NUM_SLOTS-1:0] slot_multi;
  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 fn_here;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_multi[s] = $countones(present[s*FUNCS +: FUNCS]) > 1;
    assign slot_hit[s]   = (int'(sel.slot) == s) && present[s*FUNCS + int'(sel.func)];
  end

  always_comb begin
    off      = eff_offset(sel.off, lane);
    fn_here  = |slot_hit;
    multi_fn = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (int'(sel.slot) == s) multi_fn = slot_multi[s];
    acc_ok   = fn_here && legal_size(size) && is_aligned(off, size);
  end
endmodule

// File: rtl/cfg_read_shaper.sv
module cfg_read_shaper
  import cfg_pkg::*;
(
  input  logic [31:0] raw,
  input  logic [7:0]  off,
  input  logic [2:0]  size,
  input  logic        multi_fn,
  input  logic        acc_ok,
  output logic [31:0] shaped
);
  always_comb begin
    if (!acc_ok) shaped = '1;
    else         shaped = hdr_fix(raw & size_mask(size), off, size, multi_fn);
  end
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       io_req,
  input  logic                       io_we,
  input  logic [15:0]                io_addr,
  input  logic [2:0]                 io_size,
  input  logic [31:0]                io_wdata,
  output logic                       io_rsp_valid,
  output logic [31:0]                io_rdata,
  input  logic [NUM_SLOTS*FUNCS-1:0] present,
  output logic                       cfg_req,
  output logic                       cfg_we,
  output logic [4:0]                 cfg_slot,
  output logic [2:0]                 cfg_func,
  output logic [7:0]                 cfg_off,
  output logic [2:0]                 cfg_size,
  output logic [31:0]                cfg_wdata,
  input  logic [31:0]                cfg_rdata
);
  cfg_sel_t    sel_q;
  logic        hit_addr, hit_data, claimed;
  logic        addr_load, acc_ok, multi_fn;
  logic [7:0]  off;
  logic [31:0] shaped, rdata_d;

  assign hit_addr  = io_addr == ADDR_PORT;
  assign hit_data  = io_addr[15:2] == DATA_BASE[15:2];
  assign claimed   = io_req && (hit_addr || hit_data);
  assign addr_load = io_req && hit_addr && io_we && (io_size == 3'd4);

  cfg_addr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .wdata(io_wdata), .sel_q(sel_q)
  );

  cfg_access_check #(.NUM_SLOTS(NUM_SLOTS)) u_check (
    .sel(sel_q), .lane(io_addr[1:0]), .size(io_size), .present(present),
    .off(off), .acc_ok(acc_ok), .multi_fn(multi_fn)
  );

  cfg_read_shaper u_shape (
    .raw(cfg_rdata), .off(off), .size(io_size), .multi_fn(multi_fn),
    .acc_ok(acc_ok), .shaped(shaped)
  );

  assign cfg_req   = io_req && hit_data && acc_ok;
  assign cfg_we    = io_we;
  assign cfg_slot  = sel_q.slot;
  assign cfg_func  = sel_q.func;
  assign cfg_off   = off;
  assign cfg_size  = io_size;
  assign cfg_wdata = io_wdata;

  always_comb begin
    if (io_we)         rdata_d = '0;
    else if (hit_addr) rdata_d = '1;
    else               rdata_d = shaped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rsp_valid <= 1'b0;
      io_rdata     <= '0;
    end else begin
      io_rsp_valid <= claimed;
      if (claimed) io_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk
  import cfg_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       io_req,
  input logic                       io_we,
  input logic [15:0]                io_addr,
  input logic [2:0]                 io_size,
  input logic                       io_rsp_valid,
  input logic [31:0]                io_rdata,
  input logic [NUM_SLOTS*FUNCS-1:0] present,
  input logic                       cfg_req,
  input logic [4:0]                 cfg_slot,
  input logic [2:0]                 cfg_func,
  input logic [7:0]                 cfg_off,
  input logic [2:0]                 cfg_size,
  input logic                       hit_data,
  input logic                       acc_ok,
  input cfg_sel_t                   sel_q
);
  assert_fwd_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ((cfg_off & {5'd0, cfg_size - 3'd1}) == 8'd0));

  assert_fwd_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> present[int'(cfg_slot) * FUNCS + int'(cfg_func)]);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_we && io_addr == ADDR_PORT && io_size != 3'd4) |=> $stable(sel_q));

  assert_reject_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_we && hit_data && !acc_ok) |=> (io_rdata == 32'hFFFF_FFFF));

  assert_narrow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_we && hit_data && acc_ok && io_size == 3'd1) |=> (io_rdata[31:8] == 24'd0));

  assert_no_stray_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && (hit_data || io_addr == ADDR_PORT)) |=> !io_rsp_valid);

  assert_no_idle_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !io_req |-> !cfg_req);
endmodule

bind cfg_port_decoder cfg_port_decoder_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
  .io_size(io_size), .io_rsp_valid(io_rsp_valid), .io_rdata(io_rdata),
  .present(present), .cfg_req(cfg_req), .cfg_slot(cfg_slot), .cfg_func(cfg_func),
  .cfg_off(cfg_off), .cfg_size(cfg_size), .hit_data(hit_data), .acc_ok(acc_ok),
  .sel_q(sel_q)
);

// File: tb/cfg_port_decoder_bench.sv
`timescale 1ns/1ps
module cfg_port_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [2:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_rsp_valid;
  logic [31:0] io_rdata;
  logic [255:0] present = '0;
  logic        cfg_req, cfg_we;
  logic [4:0]  cfg_slot;
  logic [2:0]  cfg_func;
  logic [7:0]  cfg_off;
  logic [2:0]  cfg_size;
  logic [31:0] cfg_wdata, cfg_rdata;

  int tests = 0, fails = 0;
  int m_sel = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_port_decoder u_cfg_port_decoder (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_size(io_size), .io_wdata(io_wdata), .io_rsp_valid(io_rsp_valid),
    .io_rdata(io_rdata), .present(present), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_slot(cfg_slot), .cfg_func(cfg_func), .cfg_off(cfg_off), .cfg_size(cfg_size),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // register file model: byte at offset o = o XOR {slot,func}
  always_comb begin
    for (int k = 0; k < 4; k++)
      cfg_rdata[k*8 +: 8] = (cfg_off + 8'(k)) ^ {cfg_slot, cfg_func};
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int fn_count(int slot);
    int n = 0;
    for (int f = 0; f < 8; f++) if (present[slot*8 + f]) n++;
    return n;
  endfunction

  // behavioural model of one access: returns expected forward and data
  task automatic access(input logic [15:0] a, input bit we, input int sz,
                        input logic [31:0] wd, input string req);
    int slot, func, off, mask;
    bit claim, data, ok;
    logic [31:0] exp;
    slot  = (m_sel >> 11) & 31;
    func  = (m_sel >> 8) & 7;
    off   = ((m_sel & 255) + (int'(a) - 'hCFC)) & 255;
    data  = (a >= 16'hCFC) && (a <= 16'hCFF);
    claim = data || (a == 16'hCF8);
    ok    = data && (sz == 1 || sz == 2 || sz == 4) && (off % sz == 0) && present[slot*8 + func];
    exp   = 32'hFFFF_FFFF;
    if (ok) begin
      exp = 0;
      for (int k = 0; k < sz; k++) begin
        int b;
        b = ((off + k) & 255) ^ ((slot << 3) | func);
        if (off + k == 14) b = (fn_count(slot) > 1) ? (b | 128) : (b & 127);
        exp = exp | (32'(b) << (8 * k));
      end
    end
    @(negedge clk);
    io_req = 1; io_we = we; io_addr = a; io_size = 3'(sz); io_wdata = wd;
    #1;
    check(cfg_req == ok, req, 32'(cfg_req), 32'(ok));
    if (ok) begin
      check({cfg_slot, cfg_func} == 8'((slot << 3) | func), req, 32'({cfg_slot, cfg_func}), 32'((slot << 3) | func));
      check(cfg_off == 8'(off), req, 32'(cfg_off), 32'(off));
      check(cfg_we == we && cfg_size == 3'(sz), req, 32'({cfg_we, cfg_size}), 32'({we, 3'(sz)}));
      if (we) check(cfg_wdata == wd, req, cfg_wdata, wd);
    end
    @(posedge clk);
    #1;
    io_req = 0;
    if (a == 16'hCF8 && we && sz == 4) m_sel = int'(wd);
    if (a == 16'hCF8 && !we) exp = 32'hFFFF_FFFF;
    check(io_rsp_valid == claim, req, 32'(io_rsp_valid), 32'(claim));
    if (claim && !we) check(io_rdata == exp, req, io_rdata, exp);
  endtask

  task automatic set_sel(input int slot, input int func, input int off, input int extra);
    access(16'hCF8, 1, 4, 32'(extra | (slot << 11) | (func << 8) | off), "R1");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    present[3*8 + 0]  = 1'b1;
    present[3*8 + 2]  = 1'b1;
    present[5*8 + 0]  = 1'b1;
    present[31*8 + 7] = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R10: quiet during reset
    check(!io_rsp_valid && !cfg_req, "R10", 32'({io_rsp_valid, cfg_req}), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check(!io_rsp_valid, "R10", 32'(io_rsp_valid), 0);
    check({cfg_slot, cfg_func, cfg_off} == 16'd0, "R1", 32'({cfg_slot, cfg_func, cfg_off}), 0);

    // R1 with bus and enable set; R4/R7 full read
    set_sel(3, 0, 'h00, 32'h8007_0000);
    access(16'hCFC, 0, 4, 0, "R4");
    access(16'hCFD, 0, 1, 0, "R3");
    access(16'hCFE, 0, 2, 0, "R7");
    // R8 multi-function slot, header at lane 2 / lane 0 / 1-byte via CFE
    set_sel(3, 0, 'h0C, 0);
    access(16'hCFC, 0, 4, 0, "R8");
    access(16'hCFE, 0, 1, 0, "R8");
    access(16'hCFE, 0, 2, 0, "R8");
    set_sel(3, 2, 'h0C, 0);
    access(16'hCFE, 0, 2, 0, "R8");
    // R8 single-function slot, raw bit 7 set must clear
    set_sel(31, 7, 'h0C, 0);
    access(16'hCFC, 0, 4, 0, "R8");
    access(16'hCFF, 0, 1, 0, "R8");
    set_sel(5, 0, 'h0E, 0);
    access(16'hCFC, 0, 2, 0, "R8");
    // R5 misaligned and illegal sizes
    set_sel(3, 0, 'h00, 0);
    access(16'hCFD, 0, 2, 0, "R5");
    access(16'hCFE, 0, 4, 0, "R5");
    access(16'hCFC, 0, 3, 0, "R5");
    access(16'hCFD, 1, 2, 32'h1234, "R5");
    // R6 absent function
    set_sel(3, 1, 'h00, 0);
    access(16'hCFC, 0, 4, 0, "R6");
    access(16'hCFC, 1, 4, 32'hDEAD_BEEF, "R6");
    set_sel(7, 0, 'h10, 0);
    access(16'hCFC, 0, 1, 0, "R6");
    // R4 forwarded write with offset from lane
    set_sel(3, 2, 'h40, 0);
    access(16'hCFE, 1, 2, 32'h0000_ABCD, "R4");
    access(16'hCFC, 1, 4, 32'hCAFE_F00D, "R4");
    // R3 offset wrap near top
    set_sel(3, 2, 'hFC, 0);
    access(16'hCFF, 0, 1, 0, "R3");
    // R2 narrow address writes ignored; address read gives ones
    access(16'hCF8, 1, 2, 32'h0000_0800, "R2");
    access(16'hCF8, 1, 1, 32'h0000_0000, "R2");
    access(16'hCFC, 0, 4, 0, "R2");
    access(16'hCF8, 0, 4, 0, "R2");
    // R9 unrelated ports
    access(16'h0080, 0, 1, 0, "R9");
    access(16'h0CF9, 1, 1, 32'h5, "R9");
    access(16'h0D00, 0, 4, 0, "R9");
    access(16'hCFC, 0, 4, 0, "R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule